// File: doc/BRIEF.md
# NAND Status Poll Engine

This block carries out one hardware status-wait operation on a NAND flash bus. It is handed a 128-bit command word and a start pulse. It then asserts chip enable and latches a command byte into the flash with command-latch timing. When the command asks for it, it latches up to four address bytes with address-latch timing. After that it reads one status byte with read-enable timing, over and over. It stops when the status byte, ANDed with a mask from the command, equals a compare byte from the command. It then reports completion with a one-cycle done pulse.

Every phase of the bus waveform is timed by a 3-bit select in the command. The select picks one of eight delays on a delay-table input bus. A table value of N holds the phase for N+1 clock cycles. A maximum poll count bounds the loop. When that many reads pass without a match, the engine ends with a timeout flag. A command that is malformed is refused with an error flag and causes no bus activity. This lets firmware hand off the busy-wait after program or erase operations and collect one completion event.

Top module: `nand_status_poller`

## Requirements
- R1: While reset is held and after it is released, ce_n, we_n and re_n are 1; cle, ale, dq_oe, busy and done are 0.
- R2: A command is refused if the marker nibble (bits 99:96) is not 9, if the opcode nibble (bits 3:0) is not the OPCODE parameter (default 4'hB), or if any reserved bit (7:4, 31:25, 47:44, 63:60) is set. A refused command gives done with err_marker in the cycle after the start cycle, and ce_n, we_n, re_n, cle and ale do not change.
- R3: Delay table entry k is tm_delays[k*DW +: DW], and a value N there holds a phase for N+1 cycles. The command phase drives cle high and puts bits 15:8 on dq_out. Its write-enable low pulse lasts for the entry selected by bits 21:19. Bits 18:16 select the setup before the pulse and bits 24:22 select the hold after it.
- R4: When the indicator byte (bits 39:32) equals 5, the engine sends min(count,4) address bytes with ale high. The count is bits 43:40. The bytes come from bits 95:64, lowest byte first. Each write-enable low pulse lasts for the entry selected by bits 53:51. Bits 50:48 select the setup, bits 56:54 the hold, and bits 59:57 the gap after the last byte.
- R5: When the indicator byte is anything other than 5, ale never rises during the operation.
- R6: Each status read drives re_n low for the entry selected by bits 121:119. The byte on dq_in is captured as re_n rises. Between two reads, re_n stays high for (entry at bits 124:122)+1 + (entry at bits 127:125)+1 cycles. Bits 118:116 select the setup before the first read.
- R7: Polling ends after the first read whose byte ANDed with bits 107:100 equals bits 115:108. done is then raised with both error flags low, and status_out holds that byte.
- R8: If max_polls reads (with 0 treated as 1) all fail to match, the engine performs exactly that many reads and then raises done with err_timeout.
- R9: done is a single-cycle pulse, and ce_n is high in the done cycle. busy is high from the cycle after an accepted start through the done cycle. ce_n is low whenever we_n or re_n is low.
- R10: A start pulse while busy is ignored. The running operation keeps its own command and read count.
- R11: At most one of cle, ale and the read strobe (re_n low) is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `cmd` |
| cmd | input | 128 | Status-wait command word |
| tm_delays | input | 8*DW | Eight resolved phase delays, entry k at bits k*DW +: DW |
| max_polls | input | PW | Maximum number of status reads before timeout |
| dq_in | input | 8 | Data bus from flash |
| dq_out | output | 8 | Data bus to flash |
| dq_oe | output | 1 | Data bus output enable |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err_marker | output | 1 | Command refused (valid with done) |
| err_timeout | output | 1 | Poll limit reached (valid with done) |
| status_out | output | 8 | Last status byte read |

## Verification
A flash-side model counts latched bytes and measures the strobe widths at the pins. A delay select taken from the wrong bit field, or an off-by-one in the N+1 timing, therefore shows up as a wrong pulse width. The masked compare is exercised with a byte whose unmasked bits differ from the compare value. An engine that compared the raw byte would keep polling, and would either time out or read a different status_out. The address count is driven above four, and the poll limit is driven at both zero and three. A design that failed to clamp the count would emit extra ALE bytes, and a limit check that was off by one would do one read too many or too few. A malformed command and a mid-operation start check that the error path stays off the bus and that a running operation cannot be restarted.

// File: rtl/nand_status_poller.sv
module nand_status_poller #(
  parameter int DW = 8,
  parameter int PW = 16,
  parameter logic [3:0] OPCODE = 4'hB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [127:0]    cmd,
  input  logic [8*DW-1:0] tm_delays,
  input  logic [PW-1:0]   max_polls,
  input  logic [7:0]      dq_in,
  output logic [7:0]      dq_out,
  output logic            dq_oe,
  output logic            ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic            busy,
  output logic            done,
  output logic            err_marker,
  output logic            err_timeout,
  output logic [7:0]      status_out
);

  typedef enum logic [3:0] {
    S_IDLE, S_C_SU, S_C_WE, S_C_HO, S_A_SU, S_A_WE, S_A_HO, S_A_GAP,
    S_R_SU, S_R_LO, S_R_HI, S_R_GAP, S_DONE
  } st_t;

  st_t           state;
  logic [DW-1:0] tmr;
  logic [PW-1:0] polls, lim_q;
  logic [1:0]    aidx;
  logic [7:0]    cbyte, mask_q, cmp_q, stat_q;
  logic [31:0]   addr_q;
  logic [2:0]    c2, c3, a1, a2, a3, a4, r1, r2, r3, r4;
  logic [2:0]    acnt;
  logic          use_addr;

  function automatic logic [DW-1:0] dly(input logic [2:0] s);
    return tm_delays[s*DW +: DW];
  endfunction

  wire        rsvd_clear = ~|{cmd[7:4], cmd[31:25], cmd[47:44], cmd[63:60]};
  wire        cmd_ok     = (cmd[99:96] == 4'd9) && (cmd[3:0] == OPCODE) && rsvd_clear;
  wire [2:0]  cnt_in     = (cmd[43:40] > 4'd4) ? 3'd4 : cmd[42:40];
  wire        tmr_zero   = (tmr == '0);
  wire        hit        = ((stat_q & mask_q) == cmp_q);
  wire        last_addr  = ({1'b0, aidx} == acnt - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tmr         <= '0;
      polls       <= '0;
      lim_q       <= '0;
      aidx        <= '0;
      cbyte       <= '0;
      mask_q      <= '0;
      cmp_q       <= '0;
      stat_q      <= '0;
      addr_q      <= '0;
      {c2, c3, a1, a2, a3, a4, r1, r2, r3, r4} <= '0;
      acnt        <= '0;
      use_addr    <= 1'b0;
      err_marker  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          err_marker  <= 1'b0;
          err_timeout <= 1'b0;
          if (!cmd_ok) begin
            err_marker <= 1'b1;
            state      <= S_DONE;
          end else begin
            cbyte    <= cmd[15:8];
            c2       <= cmd[21:19];
            c3       <= cmd[24:22];
            use_addr <= (cmd[39:32] == 8'd5) && (cnt_in != 3'd0);
            acnt     <= cnt_in;
            a1       <= cmd[50:48];
            a2       <= cmd[53:51];
            a3       <= cmd[56:54];
            a4       <= cmd[59:57];
            addr_q   <= cmd[95:64];
            mask_q   <= cmd[107:100];
            cmp_q    <= cmd[115:108];
            r1       <= cmd[118:116];
            r2       <= cmd[121:119];
            r3       <= cmd[124:122];
            r4       <= cmd[127:125];
            lim_q    <= (max_polls == '0) ? PW'(1) : max_polls;
            polls    <= '0;
            aidx     <= '0;
            tmr      <= dly(cmd[18:16]);
            state    <= S_C_SU;
          end
        end
        S_DONE: state <= S_IDLE;
        default: if (!tmr_zero) begin
          tmr <= tmr - 1'b1;
        end else begin
          case (state)
            S_C_SU: begin state <= S_C_WE; tmr <= dly(c2); end
            S_C_WE: begin state <= S_C_HO; tmr <= dly(c3); end
            S_C_HO: if (use_addr) begin
                state <= S_A_SU; tmr <= dly(a1);
              end else begin
                state <= S_R_SU; tmr <= dly(r1);
              end
            S_A_SU: begin state <= S_A_WE; tmr <= dly(a2); end
            S_A_WE: begin state <= S_A_HO; tmr <= dly(a3); end
            S_A_HO: if (last_addr) begin
                state <= S_A_GAP; tmr <= dly(a4);
              end else begin
                aidx <= aidx + 1'b1; state <= S_A_SU; tmr <= dly(a1);
              end
            S_A_GAP: begin state <= S_R_SU; tmr <= dly(r1); end
            S_R_SU:  begin state <= S_R_LO; tmr <= dly(r2); end
            S_R_LO: begin
              stat_q <= dq_in;
              polls  <= polls + 1'b1;
              state  <= S_R_HI;
              tmr    <= dly(r3);
            end
            S_R_HI: if (hit) begin
                state <= S_DONE;
              end else if (polls >= lim_q) begin
                err_timeout <= 1'b1;
                state       <= S_DONE;
              end else begin
                state <= S_R_GAP; tmr <= dly(r4);
              end
            S_R_GAP: begin state <= S_R_LO; tmr <= dly(r2); end
            default: state <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  wire in_cmd  = (state == S_C_SU) || (state == S_C_WE) || (state == S_C_HO);
  wire in_addr = (state == S_A_SU) || (state == S_A_WE) || (state == S_A_HO);

  assign cle        = in_cmd;
  assign ale        = in_addr;
  assign we_n       = !((state == S_C_WE) || (state == S_A_WE));
  assign re_n       = (state != S_R_LO);
  assign ce_n       = (state == S_IDLE) || (state == S_DONE);
  assign dq_oe      = in_cmd || in_addr;
  assign dq_out     = in_cmd ? cbyte : addr_q[8*aidx +: 8];
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign status_out = stat_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cle, ale, !re_n}));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);

  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_marker) |-> ($past(ce_n) && $past(start)));

  // R8
  timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_timeout) |-> (polls == lim_q));

  // R7
  match_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_marker && !err_timeout) |-> ((status_out & mask_q) == cmp_q));

endmodule

// File: tb/nand_status_poller_tb.sv
module nand_status_poller_tb_top;
  localparam int DW = 8;
  localparam int PW = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [127:0] cmd = '0;
  logic [8*DW-1:0] tm_delays;
  logic [PW-1:0] max_polls = 16'd8;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out, status_out;
  logic dq_oe, ce_n, cle, ale, we_n, re_n, busy, done, err_marker, err_timeout;

  int tests = 0, fails = 0, cyc = 0;

  nand_status_poller #(.DW(DW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .tm_delays(tm_delays),
    .max_polls(max_polls), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .busy(busy),
    .done(done), .err_marker(err_marker), .err_timeout(err_timeout),
    .status_out(status_out));

  always #4 clk = ~clk;

  // entry k holds value k, so select k lasts k+1 cycles
  initial for (int k = 0; k < 8; k++) tm_delays[k*DW +: DW] = DW'(k);

  // flash-side model
  logic [7:0] resp [0:7];
  int cle_cnt, ale_cnt, rd_cnt, we_w, re_w, gap_w, ale_rises, wlow, rlow, rhigh;
  logic [7:0] cle_byte, ale_bytes [0:7];
  logic pwe = 1, pre = 1, pale = 0, lat_cle, lat_ale;
  logic [7:0] lat_dq;

  task automatic clr_model();
    cle_cnt = 0; ale_cnt = 0; rd_cnt = 0; we_w = 0; re_w = 0; gap_w = -1;
    ale_rises = 0; wlow = 0; rlow = 0; rhigh = 0; cle_byte = 8'h00;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (ale && !pale) ale_rises++;
    if (!we_n) begin wlow++; lat_cle = cle; lat_ale = ale; lat_dq = dq_out; end
    if (!pwe && we_n) begin
      we_w = wlow; wlow = 0;
      if (lat_cle) begin cle_cnt++; cle_byte = lat_dq; end
      if (lat_ale && ale_cnt < 8) begin ale_bytes[ale_cnt] = lat_dq; ale_cnt++; end
    end
    if (pre && !re_n) begin
      if (rd_cnt > 0) gap_w = rhigh;
      dq_in = resp[(rd_cnt < 8) ? rd_cnt : 7];
      rd_cnt++;
    end
    if (!re_n) rlow++;
    if (!pre && re_n) begin re_w = rlow; rlow = 0; rhigh = 0; end
    if (re_n && !ce_n) rhigh++;
    pwe = we_n; pre = re_n; pale = ale;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [7:0] cb, input logic [2:0] c1, c2, c3,
      input logic [7:0] ind, input logic [3:0] cnt, input logic [2:0] a1, a2, a3, a4,
      input logic [31:0] adr, input logic [3:0] mark, input logic [7:0] msk, cmpb,
      input logic [2:0] r1, r2, r3, r4);
    logic [127:0] c = '0;
    c[3:0] = 4'hB; c[15:8] = cb; c[18:16] = c1; c[21:19] = c2; c[24:22] = c3;
    c[39:32] = ind; c[43:40] = cnt; c[50:48] = a1; c[53:51] = a2; c[56:54] = a3;
    c[59:57] = a4; c[95:64] = adr; c[99:96] = mark; c[107:100] = msk;
    c[115:108] = cmpb; c[118:116] = r1; c[121:119] = r2; c[124:122] = r3;
    c[127:125] = r4;
    return c;
  endfunction

  int busy_bad;

  task automatic run(input logic [127:0] c, input bit restart);
    int n;
    clr_model();
    busy_bad = 0;
    @(negedge clk);
    cmd = c; start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 4000) begin
      if (!busy) busy_bad++;
      if (restart && n == 10) begin
        cmd = mk(8'hAA, 0,0,0, 8'd5, 4'd4, 0,0,0,0, 32'h0, 4'd9, 8'h00, 8'h00, 0,0,0,0);
        start = 1;
      end else start = 0;
      @(negedge clk); n++;
    end
    start = 0;
    chk(done === 1'b1, "R9 done reached", done, 1);
    chk(ce_n === 1'b1 && busy === 1'b1, "R9 ce released/busy at done", {ce_n, busy}, 2'b11);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done single pulse", {done, busy}, 0);
  endtask

  task automatic t_reset();
    chk({ce_n, we_n, re_n, cle, ale, dq_oe, busy, done} === 8'b11100000, "R1 reset outputs",
        {ce_n, we_n, re_n, cle, ale, dq_oe, busy, done}, 8'b11100000);
  endtask

  task automatic t_reject(input logic [127:0] c, input string tag);
    clr_model();
    @(negedge clk);
    cmd = c; start = 1;
    @(negedge clk);
    start = 0;
    chk(done && err_marker && !err_timeout, tag, {done, err_marker, err_timeout}, 3'b110);
    repeat (3) @(negedge clk);
    chk(cle_cnt + rd_cnt + ale_rises == 0 && ce_n, "R2 no bus activity", cle_cnt + rd_cnt, 0);
  endtask

  task automatic t_plain();
    resp[0] = 8'h00; resp[1] = 8'h40; resp[2] = 8'h40;
    max_polls = 8;
    run(mk(8'h70, 3'd1, 3'd2, 3'd1, 8'd0, 4'd3, 0,0,0,0, 32'h44332211, 4'd9,
           8'hFF, 8'h40, 3'd1, 3'd3, 3'd2, 3'd4), 0);
    chk(cle_cnt == 1 && cle_byte == 8'h70, "R3 command byte", cle_byte, 8'h70);
    chk(we_w == 3, "R3 WE low width", we_w, 3);
    chk(ale_rises == 0, "R5 no address phase", ale_rises, 0);
    chk(rd_cnt == 2, "R7 reads until match", rd_cnt, 2);
    chk(re_w == 4, "R6 RE low width", re_w, 4);
    chk(gap_w == 8, "R6 RE high between reads", gap_w, 8);
    chk(status_out == 8'h40 && !err_timeout && !err_marker, "R7 status/flags",
        status_out, 8'h40);
    chk(busy_bad == 0, "R9 busy during op", busy_bad, 0);
  endtask

  task automatic t_addr();
    resp[0] = 8'h1F; resp[1] = 8'h5F; resp[2] = 8'h5F;
    max_polls = 8;
    run(mk(8'h71, 0,0,0, 8'd5, 4'd3, 3'd0, 3'd4, 3'd1, 3'd2, 32'h44332211, 4'd9,
           8'hE0, 8'h40, 0, 3'd0, 0, 0), 0);
    chk(ale_cnt == 3, "R4 address byte count", ale_cnt, 3);
    chk(ale_bytes[0] == 8'h11 && ale_bytes[1] == 8'h22 && ale_bytes[2] == 8'h33,
        "R4 address order", {ale_bytes[0], ale_bytes[1], ale_bytes[2]}, 24'h112233);
    chk(we_w == 5, "R4 address WE width", we_w, 5);
    chk(rd_cnt == 2 && status_out == 8'h5F, "R7 masked match", status_out, 8'h5F);
  endtask

  task automatic t_clamp();
    resp[0] = 8'h01;
    max_polls = 8;
    run(mk(8'h72, 0,0,0, 8'd5, 4'd7, 0,0,0,0, 32'hDDCCBBAA, 4'd9,
           8'h01, 8'h01, 0,0,0,0), 0);
    chk(ale_cnt == 4 && ale_bytes[3] == 8'hDD, "R4 count clamped to four", ale_cnt, 4);
  endtask

  task automatic t_timeout(input logic [PW-1:0] lim, input int exp_rd);
    for (int i = 0; i < 8; i++) resp[i] = 8'h00;
    max_polls = lim;
    run(mk(8'h70, 0,0,0, 8'd0, 4'd0, 0,0,0,0, 32'h0, 4'd9,
           8'h40, 8'h40, 0,0,0,0), 0);
    chk(err_timeout && !err_marker, "R8 timeout flag", err_timeout, 1);
    chk(rd_cnt == exp_rd, "R8 read count at timeout", rd_cnt, exp_rd);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 8; i++) resp[i] = 8'h00;
    max_polls = 5;
    run(mk(8'h70, 0,0,0, 8'd0, 4'd0, 0,0,0,0, 32'h0, 4'd9,
           8'h80, 8'h80, 0,0,0,0), 1);
    chk(rd_cnt == 5 && ale_rises == 0 && cle_cnt == 1, "R10 start ignored while busy",
        rd_cnt, 5);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) resp[i] = 8'h00;
    clr_model();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reject(mk(8'h70, 0,0,0, 8'd0, 4'd0, 0,0,0,0, 32'h0, 4'd3, 8'hFF, 8'h00, 0,0,0,0),
             "R2 bad marker");
    begin
      logic [127:0] c;
      c = mk(8'h70, 0,0,0, 8'd0, 4'd0, 0,0,0,0, 32'h0, 4'd9, 8'hFF, 8'h00, 0,0,0,0);
      c[30] = 1'b1;
      t_reject(c, "R2 reserved bit set");
    end
    t_plain();
    t_addr();
    t_clamp();
    t_timeout(16'd3, 3);
    t_timeout(16'd0, 1);
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule